// File: doc/BRIEF.md
# AXI-Lite Narrow-to-Wide Data Width Bridge

The bridge connects an AXI-Lite requester with a narrow data bus to an AXI-Lite completer with a wider data bus. The wide width must be a power-of-two multiple of the narrow width, and at least twice as wide. Addresses and protection bits pass through on both address channels without any change. Write and read responses also pass through. The bridge never produces a response of its own.

The narrow bus maps onto one lane of the wide bus. The lane number comes from the address bits just above the narrow byte offset.

- **Writes:** the narrow data is copied into every lane of the wide bus. The strobe is asserted only in the selected lane.
- **Reads:** the lane number is stored when the read address is accepted. The stored entries form an in-order queue of bounded depth. When read data returns, the oldest stored lane picks the narrow slice to return.

Write address and write data are joined on the narrow side, so the lane of each write is known when its data moves. On the wide side each of the two channels completes on its own.

Top module: `axil_upsizer`

## Requirements
- R1: The lane number is the address field of width log2(WIDE_W/NARROW_W) that starts at bit log2(NARROW_W/8). With the defaults (32 to 128 bits) it is address bits [3:2].
- R2: While the wide write-address valid is high, the wide write address and protection equal the narrow write address and protection.
- R3: A narrow write address and its write data are accepted in the same cycle, and only once both are valid. Each one is offered once on the wide side. After the wide side takes one of them, its valid stays low until the narrow pair is accepted.
- R4: The wide strobe carries the narrow strobe in lane bits [lane*NARROW_W/8 +: NARROW_W/8]. All other strobe bits are zero.
- R5: Every NARROW_W-bit slice of the wide write data equals the narrow write data.
- R6: Write-response valid, code and ready pass between the two ports unchanged, in the order the wide side returns them.
- R7: When fewer than RD_DEPTH reads are outstanding, the read address and protection are forwarded unchanged. Narrow read-address ready then equals wide read-address ready.
- R8: Each read response returns the wide data shifted right by lane*NARROW_W and truncated to NARROW_W bits, with the response code unchanged. The lane used is the one recorded for the oldest outstanding read. Valid and ready pass through.
- R9: When RD_DEPTH reads are outstanding, narrow read-address ready and wide read-address valid are both low until a read response is accepted.
- R10: After reset no read is outstanding. With all input valids low, every output valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_aw_addr_i | input | ADDR_W | Narrow write address |
| s_aw_prot_i | input | 3 | Narrow write protection |
| s_aw_valid_i | input | 1 | Narrow write address valid |
| s_aw_ready_o | output | 1 | Narrow write address ready |
| s_w_data_i | input | NARROW_W | Narrow write data |
| s_w_strb_i | input | NARROW_W/8 | Narrow write strobe |
| s_w_valid_i | input | 1 | Narrow write data valid |
| s_w_ready_o | output | 1 | Narrow write data ready |
| s_b_resp_o | output | 2 | Narrow write response code |
| s_b_valid_o | output | 1 | Narrow write response valid |
| s_b_ready_i | input | 1 | Narrow write response ready |
| s_ar_addr_i | input | ADDR_W | Narrow read address |
| s_ar_prot_i | input | 3 | Narrow read protection |
| s_ar_valid_i | input | 1 | Narrow read address valid |
| s_ar_ready_o | output | 1 | Narrow read address ready |
| s_r_data_o | output | NARROW_W | Narrow read data |
| s_r_resp_o | output | 2 | Narrow read response code |
| s_r_valid_o | output | 1 | Narrow read valid |
| s_r_ready_i | input | 1 | Narrow read ready |
| m_aw_addr_o | output | ADDR_W | Wide write address |
| m_aw_prot_o | output | 3 | Wide write protection |
| m_aw_valid_o | output | 1 | Wide write address valid |
| m_aw_ready_i | input | 1 | Wide write address ready |
| m_w_data_o | output | WIDE_W | Wide write data |
| m_w_strb_o | output | WIDE_W/8 | Wide write strobe |
| m_w_valid_o | output | 1 | Wide write data valid |
| m_w_ready_i | input | 1 | Wide write data ready |
| m_b_resp_i | input | 2 | Wide write response code |
| m_b_valid_i | input | 1 | Wide write response valid |
| m_b_ready_o | output | 1 | Wide write response ready |
| m_ar_addr_o | output | ADDR_W | Wide read address |
| m_ar_prot_o | output | 3 | Wide read protection |
| m_ar_valid_o | output | 1 | Wide read address valid |
| m_ar_ready_i | input | 1 | Wide read address ready |
| m_r_data_i | input | WIDE_W | Wide read data |
| m_r_resp_i | input | 2 | Wide read response code |
| m_r_valid_i | input | 1 | Wide read valid |
| m_r_ready_o | output | 1 | Wide read ready |

## Verification
The hardest state to reach is a full lane queue. From the ports, a full queue looks only like a withheld read-address ready, even though the wide side is ready.

The stimulus reaches it with a stretch in which the responder on the wide side holds back all read data while the requester keeps issuing reads. After the stretch the backlog drains in order.

Outside that stretch, the two wide write channels accept on independent random ready patterns. This makes the address and the data finish in different cycles, in both orders, which exercises the write join.

// File: rtl/axil_upsizer_pkg.sv
package axil_upsizer_pkg;
  typedef logic [1:0] resp_t;
  typedef logic [2:0] prot_t;

  // lane-select width, never zero
  function automatic int unsigned sel_width(int unsigned ratio);
    return (ratio > 1) ? $clog2(ratio) : 1;
  endfunction
endpackage

// File: rtl/axil_upsizer_wr_join.sv
module axil_upsizer_wr_join
  import axil_upsizer_pkg::*;
#(
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned WIDE_W   = 128,
  localparam int unsigned NB      = NARROW_W / 8,
  localparam int unsigned WB      = WIDE_W / 8,
  localparam int unsigned RATIO   = WIDE_W / NARROW_W,
  localparam int unsigned SEL_W   = sel_width(RATIO)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SEL_W-1:0]    lane_i,
  input  logic                s_aw_valid_i,
  output logic                s_aw_ready_o,
  input  logic [NARROW_W-1:0] s_w_data_i,
  input  logic [NB-1:0]       s_w_strb_i,
  input  logic                s_w_valid_i,
  output logic                s_w_ready_o,
  output logic                m_aw_valid_o,
  input  logic                m_aw_ready_i,
  output logic [WIDE_W-1:0]   m_w_data_o,
  output logic [WB-1:0]       m_w_strb_o,
  output logic                m_w_valid_o,
  input  logic                m_w_ready_i
);
  logic aw_sent_q, w_sent_q;
  logic pair, aw_fin, w_fin, done;

  assign pair         = s_aw_valid_i & s_w_valid_i;
  assign m_aw_valid_o = pair & ~aw_sent_q;
  assign m_w_valid_o  = pair & ~w_sent_q;
  assign aw_fin       = aw_sent_q | (m_aw_valid_o & m_aw_ready_i);
  assign w_fin        = w_sent_q  | (m_w_valid_o  & m_w_ready_i);
  assign done         = pair & aw_fin & w_fin;
  assign s_aw_ready_o = done;
  assign s_w_ready_o  = done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aw_sent_q <= 1'b0;
      w_sent_q  <= 1'b0;
    end else if (done) begin
      aw_sent_q <= 1'b0;
      w_sent_q  <= 1'b0;
    end else begin
      aw_sent_q <= aw_fin;
      w_sent_q  <= w_fin;
    end
  end

  for (genvar l = 0; l < RATIO; l++) begin : g_lane
    assign m_w_data_o[l*NARROW_W +: NARROW_W] = s_w_data_i;
    assign m_w_strb_o[l*NB +: NB] = (lane_i == SEL_W'(l)) ? s_w_strb_i : '0;
  end
endmodule

// File: rtl/axil_upsizer_lane_fifo.sv
module axil_upsizer_lane_fifo #(
  parameter int unsigned WIDTH = 2,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             full_o,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o = (cnt_q == CNT_W'(DEPTH));
  assign data_o = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= bump(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= bump(rd_ptr_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (!push_i && pop_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= data_i;
  end
endmodule

// File: rtl/axil_upsizer_rd_slice.sv
module axil_upsizer_rd_slice
  import axil_upsizer_pkg::*;
#(
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned WIDE_W   = 128,
  localparam int unsigned RATIO   = WIDE_W / NARROW_W,
  localparam int unsigned SEL_W   = sel_width(RATIO)
) (
  input  logic [WIDE_W-1:0]   wide_i,
  input  logic [SEL_W-1:0]    lane_i,
  output logic [NARROW_W-1:0] narrow_o
);
  logic [NARROW_W-1:0] lanes [RATIO];

  for (genvar l = 0; l < RATIO; l++) begin : g_split
    assign lanes[l] = wide_i[l*NARROW_W +: NARROW_W];
  end

  assign narrow_o = lanes[lane_i];
endmodule

// File: rtl/axil_upsizer.sv
module axil_upsizer
  import axil_upsizer_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned WIDE_W   = 128,
  parameter int unsigned RD_DEPTH = 4,
  localparam int unsigned NB      = NARROW_W / 8,
  localparam int unsigned WB      = WIDE_W / 8,
  localparam int unsigned RATIO   = WIDE_W / NARROW_W,
  localparam int unsigned OFFS_W  = $clog2(NB),
  localparam int unsigned SEL_W   = sel_width(RATIO)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   s_aw_addr_i,
  input  logic [2:0]          s_aw_prot_i,
  input  logic                s_aw_valid_i,
  output logic                s_aw_ready_o,
  input  logic [NARROW_W-1:0] s_w_data_i,
  input  logic [NB-1:0]       s_w_strb_i,
  input  logic                s_w_valid_i,
  output logic                s_w_ready_o,
  output logic [1:0]          s_b_resp_o,
  output logic                s_b_valid_o,
  input  logic                s_b_ready_i,
  input  logic [ADDR_W-1:0]   s_ar_addr_i,
  input  logic [2:0]          s_ar_prot_i,
  input  logic                s_ar_valid_i,
  output logic                s_ar_ready_o,
  output logic [NARROW_W-1:0] s_r_data_o,
  output logic [1:0]          s_r_resp_o,
  output logic                s_r_valid_o,
  input  logic                s_r_ready_i,
  output logic [ADDR_W-1:0]   m_aw_addr_o,
  output logic [2:0]          m_aw_prot_o,
  output logic                m_aw_valid_o,
  input  logic                m_aw_ready_i,
  output logic [WIDE_W-1:0]   m_w_data_o,
  output logic [WB-1:0]       m_w_strb_o,
  output logic                m_w_valid_o,
  input  logic                m_w_ready_i,
  input  logic [1:0]          m_b_resp_i,
  input  logic                m_b_valid_i,
  output logic                m_b_ready_o,
  output logic [ADDR_W-1:0]   m_ar_addr_o,
  output logic [2:0]          m_ar_prot_o,
  output logic                m_ar_valid_o,
  input  logic                m_ar_ready_i,
  input  logic [WIDE_W-1:0]   m_r_data_i,
  input  logic [1:0]          m_r_resp_i,
  input  logic                m_r_valid_i,
  output logic                m_r_ready_o
);
  logic [SEL_W-1:0] wr_lane, rd_lane_new, rd_lane_head;
  logic             q_full, ar_hs, r_hs;

  // write path
  assign m_aw_addr_o = s_aw_addr_i;
  assign m_aw_prot_o = s_aw_prot_i;
  assign wr_lane     = s_aw_addr_i[OFFS_W +: SEL_W];

  axil_upsizer_wr_join #(
    .NARROW_W (NARROW_W),
    .WIDE_W   (WIDE_W)
  ) i_wr_join (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lane_i       (wr_lane),
    .s_aw_valid_i (s_aw_valid_i),
    .s_aw_ready_o (s_aw_ready_o),
    .s_w_data_i   (s_w_data_i),
    .s_w_strb_i   (s_w_strb_i),
    .s_w_valid_i  (s_w_valid_i),
    .s_w_ready_o  (s_w_ready_o),
    .m_aw_valid_o (m_aw_valid_o),
    .m_aw_ready_i (m_aw_ready_i),
    .m_w_data_o   (m_w_data_o),
    .m_w_strb_o   (m_w_strb_o),
    .m_w_valid_o  (m_w_valid_o),
    .m_w_ready_i  (m_w_ready_i)
  );

  assign s_b_resp_o  = m_b_resp_i;
  assign s_b_valid_o = m_b_valid_i;
  assign m_b_ready_o = s_b_ready_i;

  // read path: stall requests while the lane queue is full
  assign m_ar_addr_o  = s_ar_addr_i;
  assign m_ar_prot_o  = s_ar_prot_i;
  assign m_ar_valid_o = s_ar_valid_i & ~q_full;
  assign s_ar_ready_o = m_ar_ready_i & ~q_full;
  assign ar_hs        = s_ar_valid_i & s_ar_ready_o;
  assign r_hs         = m_r_valid_i & s_r_ready_i;
  assign rd_lane_new  = s_ar_addr_i[OFFS_W +: SEL_W];

  axil_upsizer_lane_fifo #(
    .WIDTH (SEL_W),
    .DEPTH (RD_DEPTH)
  ) i_lane_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (ar_hs),
    .data_i (rd_lane_new),
    .full_o (q_full),
    .pop_i  (r_hs),
    .data_o (rd_lane_head)
  );

  axil_upsizer_rd_slice #(
    .NARROW_W (NARROW_W),
    .WIDE_W   (WIDE_W)
  ) i_rd_slice (
    .wide_i   (m_r_data_i),
    .lane_i   (rd_lane_head),
    .narrow_o (s_r_data_o)
  );

  assign s_r_resp_o  = m_r_resp_i;
  assign s_r_valid_o = m_r_valid_i;
  assign m_r_ready_o = s_r_ready_i;
endmodule

// File: rtl/axil_upsizer_chk.sv
module axil_upsizer_chk #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned WIDE_W   = 128,
  parameter int unsigned DEPTH    = 4,
  localparam int unsigned NB      = NARROW_W / 8,
  localparam int unsigned WB      = WIDE_W / 8,
  localparam int unsigned CNT_W   = $clog2(DEPTH + 1) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] s_aw_addr_i,
  input logic [2:0]        s_aw_prot_i,
  input logic              s_aw_valid_i,
  input logic              s_aw_ready_o,
  input logic [NB-1:0]     s_w_strb_i,
  input logic              s_w_valid_i,
  input logic              s_w_ready_o,
  input logic [ADDR_W-1:0] m_aw_addr_o,
  input logic [2:0]        m_aw_prot_o,
  input logic              m_aw_valid_o,
  input logic              m_aw_ready_i,
  input logic [WB-1:0]     m_w_strb_o,
  input logic              m_w_valid_o,
  input logic              s_b_valid_o,
  input logic              m_b_valid_i,
  input logic              s_ar_valid_i,
  input logic              s_ar_ready_o,
  input logic              m_ar_valid_o,
  input logic              s_r_valid_o,
  input logic              s_r_ready_i
);
  logic [CNT_W-1:0] out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else out_q <= out_q + CNT_W'(s_ar_valid_i & s_ar_ready_o)
                        - CNT_W'(s_r_valid_o & s_r_ready_i);
  end

  p_aw_fwd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_aw_valid_o |-> (m_aw_addr_o == s_aw_addr_i && m_aw_prot_o == s_aw_prot_i));

  p_join_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_aw_ready_o || s_w_ready_o) |-> (s_aw_ready_o && s_w_ready_o && s_aw_valid_i && s_w_valid_i));

  p_aw_once_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_aw_valid_o && m_aw_ready_i && !s_aw_ready_o) |=> !m_aw_valid_o);

  p_strb_cnt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_w_valid_o |-> ($countones(m_w_strb_o) == $countones(s_w_strb_i)));

  p_b_pass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_b_valid_o == m_b_valid_i);

  p_r_pending_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_r_valid_o |-> (out_q != '0));

  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_q <= CNT_W'(DEPTH));

  p_full_block_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_q == CNT_W'(DEPTH)) |-> (!s_ar_ready_o && !m_ar_valid_o));
endmodule

bind axil_upsizer axil_upsizer_chk #(
  .ADDR_W   (ADDR_W),
  .NARROW_W (NARROW_W),
  .WIDE_W   (WIDE_W),
  .DEPTH    (RD_DEPTH)
) i_axil_upsizer_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .s_aw_addr_i  (s_aw_addr_i),
  .s_aw_prot_i  (s_aw_prot_i),
  .s_aw_valid_i (s_aw_valid_i),
  .s_aw_ready_o (s_aw_ready_o),
  .s_w_strb_i   (s_w_strb_i),
  .s_w_valid_i  (s_w_valid_i),
  .s_w_ready_o  (s_w_ready_o),
  .m_aw_addr_o  (m_aw_addr_o),
  .m_aw_prot_o  (m_aw_prot_o),
  .m_aw_valid_o (m_aw_valid_o),
  .m_aw_ready_i (m_aw_ready_i),
  .m_w_strb_o   (m_w_strb_o),
  .m_w_valid_o  (m_w_valid_o),
  .s_b_valid_o  (s_b_valid_o),
  .m_b_valid_i  (m_b_valid_i),
  .s_ar_valid_i (s_ar_valid_i),
  .s_ar_ready_o (s_ar_ready_o),
  .m_ar_valid_o (m_ar_valid_o),
  .s_r_valid_o  (s_r_valid_o),
  .s_r_ready_i  (s_r_ready_i)
);

// File: tb/test_axil_upsizer.sv
module test_axil_upsizer;
  localparam int AW = 32, NW = 32, WW = 128, DEPTH = 4;
  localparam int NB = NW / 8, WB = WW / 8, RATIO = WW / NW;
  localparam int CYCLES = 4000, STALL_LO = 1500, STALL_HI = 1600;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0] s_aw_addr = '0, s_ar_addr = '0;
  logic [2:0]    s_aw_prot = '0, s_ar_prot = '0;
  logic          s_aw_valid = 0, s_w_valid = 0, s_b_ready = 0, s_ar_valid = 0, s_r_ready = 0;
  logic [NW-1:0] s_w_data = '0;
  logic [NB-1:0] s_w_strb = '0;
  logic          m_aw_ready = 0, m_w_ready = 0, m_b_valid = 0, m_ar_ready = 0, m_r_valid = 0;
  logic [1:0]    m_b_resp = '0, m_r_resp = '0;
  logic [WW-1:0] m_r_data = '0;

  logic          s_aw_ready, s_w_ready, s_b_valid, s_ar_ready, s_r_valid;
  logic [1:0]    s_b_resp, s_r_resp;
  logic [NW-1:0] s_r_data;
  logic [AW-1:0] m_aw_addr, m_ar_addr;
  logic [2:0]    m_aw_prot, m_ar_prot;
  logic          m_aw_valid, m_w_valid, m_b_ready, m_ar_valid, m_r_ready;
  logic [WW-1:0] m_w_data;
  logic [WB-1:0] m_w_strb;

  axil_upsizer #(.ADDR_W(AW), .NARROW_W(NW), .WIDE_W(WW), .RD_DEPTH(DEPTH)) i_axil_upsizer (
    .clk_i(clk), .rst_ni(rst_n),
    .s_aw_addr_i(s_aw_addr), .s_aw_prot_i(s_aw_prot), .s_aw_valid_i(s_aw_valid), .s_aw_ready_o(s_aw_ready),
    .s_w_data_i(s_w_data), .s_w_strb_i(s_w_strb), .s_w_valid_i(s_w_valid), .s_w_ready_o(s_w_ready),
    .s_b_resp_o(s_b_resp), .s_b_valid_o(s_b_valid), .s_b_ready_i(s_b_ready),
    .s_ar_addr_i(s_ar_addr), .s_ar_prot_i(s_ar_prot), .s_ar_valid_i(s_ar_valid), .s_ar_ready_o(s_ar_ready),
    .s_r_data_o(s_r_data), .s_r_resp_o(s_r_resp), .s_r_valid_o(s_r_valid), .s_r_ready_i(s_r_ready),
    .m_aw_addr_o(m_aw_addr), .m_aw_prot_o(m_aw_prot), .m_aw_valid_o(m_aw_valid), .m_aw_ready_i(m_aw_ready),
    .m_w_data_o(m_w_data), .m_w_strb_o(m_w_strb), .m_w_valid_o(m_w_valid), .m_w_ready_i(m_w_ready),
    .m_b_resp_i(m_b_resp), .m_b_valid_i(m_b_valid), .m_b_ready_o(m_b_ready),
    .m_ar_addr_o(m_ar_addr), .m_ar_prot_o(m_ar_prot), .m_ar_valid_o(m_ar_valid), .m_ar_ready_i(m_ar_ready),
    .m_r_data_i(m_r_data), .m_r_resp_i(m_r_resp), .m_r_valid_i(m_r_valid), .m_r_ready_o(m_r_ready)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: act=%h exp=%h", tag, $time, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // reference model state
  bit aw_done = 0, w_done = 0;
  int lane_q[$];
  logic [1:0] b_q[$];
  int m_rd_pend = 0;
  int n_wr = 0, n_rd = 0;
  bit full_seen = 0;

  initial begin : watchdog
    repeat (CYCLES + 2000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R8 watchdog expired: act=%0d reads done exp=run end", n_rd);
      finish_run();
    end
  end

  initial begin : main
    bit hs_saw, hs_maw, hs_mw, hs_mb, hs_sar, hs_mar, hs_sr, stall;
    bit pair, e_maw_v, e_mw_v, afin, wfin, e_sready, full;
    int lane;
    // R10 reset state
    repeat (3) @(posedge clk);
    #6;
    chk("R10 m_aw_valid", WW'(m_aw_valid), '0);
    chk("R10 m_w_valid",  WW'(m_w_valid),  '0);
    chk("R10 m_ar_valid", WW'(m_ar_valid), '0);
    chk("R10 s_b_valid",  WW'(s_b_valid),  '0);
    chk("R10 s_r_valid",  WW'(s_r_valid),  '0);
    rst_n = 1'b1;
    hs_saw = 0; hs_maw = 0; hs_mw = 0; hs_mb = 0; hs_sar = 0; hs_mar = 0; hs_sr = 0;
    for (int cyc = 0; cyc < CYCLES; cyc++) begin
      @(posedge clk); #1;
      // model update from handshakes of the edge just passed
      if (hs_saw) begin aw_done = 0; w_done = 0; b_q.push_back(2'($urandom_range(0, 3))); n_wr++; end
      else begin if (hs_maw) aw_done = 1; if (hs_mw) w_done = 1; end
      if (hs_mb) void'(b_q.pop_front());
      if (hs_sar) lane_q.push_back(int'((s_ar_addr / NB) % RATIO));
      if (hs_mar) m_rd_pend++;
      if (hs_sr) begin void'(lane_q.pop_front()); m_rd_pend--; n_rd++; end
      stall = (cyc >= STALL_LO && cyc < STALL_HI);
      // narrow requester
      if (!s_aw_valid || hs_saw) begin
        s_aw_valid = ($urandom_range(0, 3) != 0);
        s_aw_addr = $urandom; s_aw_prot = 3'($urandom);
      end
      if (!s_w_valid || hs_saw) begin
        s_w_valid = ($urandom_range(0, 3) != 0);
        s_w_data = $urandom; s_w_strb = NB'($urandom);
      end
      if (!s_ar_valid || hs_sar) begin
        s_ar_valid = stall || ($urandom_range(0, 2) != 0);
        s_ar_addr = $urandom; s_ar_prot = 3'($urandom);
      end
      s_b_ready = ($urandom_range(0, 3) != 0);
      s_r_ready = ($urandom_range(0, 3) != 0);
      // wide responder
      m_aw_ready = $urandom_range(0, 1);
      m_w_ready  = $urandom_range(0, 1);
      m_ar_ready = stall || ($urandom_range(0, 2) != 0);
      if (!m_b_valid || hs_mb) begin
        m_b_valid = (b_q.size() > 0) && ($urandom_range(0, 2) != 0);
        m_b_resp = (b_q.size() > 0) ? b_q[0] : 2'b00;
      end
      if (!m_r_valid || hs_sr) begin
        m_r_valid = !stall && (m_rd_pend > 0) && ($urandom_range(0, 2) != 0);
        m_r_data = {$urandom, $urandom, $urandom, $urandom};
        m_r_resp = 2'($urandom);
      end
      #5;
      // expected outputs
      pair = s_aw_valid && s_w_valid;
      e_maw_v = pair && !aw_done;
      e_mw_v = pair && !w_done;
      afin = aw_done || (e_maw_v && m_aw_ready);
      wfin = w_done || (e_mw_v && m_w_ready);
      e_sready = pair && afin && wfin;
      full = (lane_q.size() == DEPTH);
      lane = int'((s_aw_addr / NB) % RATIO);
      chk("R3 m_aw_valid", WW'(m_aw_valid), WW'(e_maw_v));
      chk("R3 m_w_valid",  WW'(m_w_valid),  WW'(e_mw_v));
      chk("R3 s_aw_ready", WW'(s_aw_ready), WW'(e_sready));
      chk("R3 s_w_ready",  WW'(s_w_ready),  WW'(e_sready));
      if (m_aw_valid) chk("R2 aw addr/prot", WW'({m_aw_prot, m_aw_addr}), WW'({s_aw_prot, s_aw_addr}));
      if (m_w_valid) begin
        chk("R1 R4 strobe lane", WW'(m_w_strb), WW'(WB'(s_w_strb) << (lane * NB)));
        chk("R5 data copies", m_w_data, {RATIO{s_w_data}});
      end
      chk("R6 b pass", WW'({s_b_valid, s_b_resp, m_b_ready}), WW'({m_b_valid, m_b_resp, s_b_ready}));
      chk("R7 m_ar_valid", WW'(m_ar_valid), WW'(s_ar_valid && !full));
      chk("R7 s_ar_ready", WW'(s_ar_ready), WW'(m_ar_ready && !full));
      if (m_ar_valid) chk("R7 ar addr/prot", WW'({m_ar_prot, m_ar_addr}), WW'({s_ar_prot, s_ar_addr}));
      chk("R8 r valid/ready", WW'({s_r_valid, m_r_ready}), WW'({m_r_valid, s_r_ready}));
      if (s_r_valid && lane_q.size() > 0) begin
        chk("R8 r data", WW'(s_r_data), WW'(NW'(m_r_data >> (lane_q[0] * NW))));
        chk("R8 r resp", WW'(s_r_resp), WW'(m_r_resp));
      end
      if (full && m_ar_ready) begin
        full_seen = 1;
        chk("R9 blocked when full", WW'({s_ar_ready, m_ar_valid}), '0);
      end
      hs_saw = s_aw_valid && s_aw_ready;
      hs_maw = m_aw_valid && m_aw_ready;
      hs_mw  = m_w_valid && m_w_ready;
      hs_mb  = m_b_valid && m_b_ready;
      hs_sar = s_ar_valid && s_ar_ready;
      hs_mar = m_ar_valid && m_ar_ready;
      hs_sr  = s_r_valid && s_r_ready;
    end
    chk("R9 queue reached full", WW'(full_seen), WW'(1));
    chk("R3 writes progressed", WW'(n_wr > 200), WW'(1));
    chk("R8 reads progressed", WW'(n_rd > 200), WW'(1));
    finished = 1;
    finish_run();
  end
endmodule